// File: doc/BRIEF.md
# Snapping Sample-Rate Register Pair

This block holds the sample-rate settings for two line channels on a simple synchronous register bus. Software writes a rate in hertz as a 16-bit unsigned number. The block does not store the raw value. It converts the value to the nearest rate the converters can run at and stores that. A read therefore returns the rate that is actually in effect. A zero value turns the channel's clock synthesizer off. Any value above the 12 kHz code jumps to the top rate.

For each line the block exports three things: a compact rate index, a synthesizer-enable bit and a sleep-permit bit. It also watches a per-line power-up request strobe. That strobe stands for clearing the line's power-down control. If the strobe arrives while the line's rate is still zero, a sticky sequencing-error flag is raised. The flag stays set until reset.

Top module: `srate_regs`

## Requirements
- R1: Line 0 lives at address 40h and line 1 at 42h. After reset both read 0000h, both indices are 15, and the enable, sleep-permit and error outputs are all 0.
- R2: The supported codes, in ascending order with indices 0 to 8, are 1C20h, 1F40h, 2024h, 20D0h, 2328h, 2580h, 282Dh, 2EE0h and 3592h. Writing any of these stores it unchanged and sets the matching index.
- R3: A nonzero write no greater than 2EE0h that is not a supported code stores the nearest supported code. Values below 1C20h store 1C20h.
- R4: A write exactly midway between two adjacent supported codes stores the lower of the two.
- R5: Any write above 2EE0h stores 3592h with index 8.
- R6: Writing zero stores 0000h, sets the index to 15 and clears the synthesizer enable. The enable is 1 exactly when the stored rate is nonzero.
- R7: Sleep-permit for a line is 1 only while that line's synthesizer enable is 1.
- R8: A power-up request (bit n of `pwrup_req`) on a line whose stored rate is zero sets that line's error flag. The check uses the value held before any write in the same cycle. The flag then stays 1 until reset. A request on a nonzero line leaves the flag unchanged.
- R9: Writes to other addresses change no register. Read data is 0000h when the address is unmapped or when `bus_rd` is low.
- R10: Read data is combinational from the stored value. A read in the cycle after a write returns the snapped value. A write to one line leaves the other line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data, requested rate in Hz |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, the stored snapped rate |
| pwrup_req | input | 2 | Per-line power-up request strobe |
| rate_idx | output | 8 | Per-line rate index, 4 bits per line (line n at bits 4n+3:4n), 15 means off |
| pll_en | output | 2 | Per-line synthesizer enable |
| sleep_ok | output | 2 | Per-line sleep permit |
| seq_err | output | 2 | Per-line sticky sequencing-error flag |

## Verification
The assertions assume that all inputs are known and stable at each rising edge once reset has been released. They also assume that a write and a read never target the same register in the same cycle. The read-side properties compare the stored value, not the incoming data. The bench drives every input one nanosecond after the rising edge. It issues each write and each read in its own cycle and samples outputs on the falling edge, so these assumptions always hold. Power-up strobes last exactly one cycle and are never combined with a write to the same line.

// File: rtl/srate_pkg.sv
package srate_pkg;

    localparam int RATE_W    = 16;
    localparam int IDX_W     = 4;
    localparam int NUM_RATES = 9;
    localparam logic [IDX_W-1:0]  IDX_OFF     = 4'hF;
    localparam logic [RATE_W-1:0] CLAMP_LIMIT = 16'h2EE0;

    typedef struct packed {
        logic [RATE_W-1:0] code;
        logic [IDX_W-1:0]  idx;
    } snap_t;

    function automatic logic [RATE_W-1:0] rate_code(input int i);
        case (i)
            0:       return 16'h1C20;
            1:       return 16'h1F40;
            2:       return 16'h2024;
            3:       return 16'h20D0;
            4:       return 16'h2328;
            5:       return 16'h2580;
            6:       return 16'h282D;
            7:       return 16'h2EE0;
            default: return 16'h3592;
        endcase
    endfunction

    // Nearest supported code; ties go to the lower code.
    function automatic snap_t snap_rate(input logic [RATE_W-1:0] v);
        snap_t r;
        logic [RATE_W:0] twice;
        logic [RATE_W:0] pair;
        r.code = rate_code(NUM_RATES-1);
        r.idx  = IDX_W'(NUM_RATES-1);
        twice  = {v, 1'b0};
        if (v == '0) begin
            r.code = '0;
            r.idx  = IDX_OFF;
        end else if (v <= CLAMP_LIMIT) begin
            for (int i = NUM_RATES-2; i >= 0; i--) begin
                pair = {1'b0, rate_code(i)} + {1'b0, rate_code(i+1)};
                if (twice <= pair) begin
                    r.code = rate_code(i);
                    r.idx  = IDX_W'(i);
                end
            end
        end
        return r;
    endfunction

    function automatic logic is_supported(input logic [RATE_W-1:0] v);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NUM_RATES; i++)
            if (v == rate_code(i)) hit = 1'b1;
        return hit;
    endfunction

endpackage

// File: rtl/srate_snap.sv
module srate_snap
    import srate_pkg::*;
(
    input  logic [RATE_W-1:0] req_rate,
    output snap_t             snapped
);
    always_comb snapped = snap_rate(req_rate);
endmodule

// File: rtl/srate_chan.sv
module srate_chan
    import srate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [RATE_W-1:0] wdata,
    input  logic              pwrup_req,
    output logic [RATE_W-1:0] rate_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic              pll_en,
    output logic              sleep_ok,
    output logic              seq_err
);
    snap_t snapped;

    srate_snap snap_i (
        .req_rate (wdata),
        .snapped  (snapped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
            idx_q  <= IDX_OFF;
        end else if (wr_hit) begin
            rate_q <= snapped.code;
            idx_q  <= snapped.idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            seq_err <= 1'b0;
        else if (pwrup_req && rate_q == '0)
            seq_err <= 1'b1;
    end

    assign pll_en   = (rate_q != '0);
    assign sleep_ok = pll_en;
endmodule

// File: rtl/srate_regs.sv
module srate_regs
    import srate_pkg::*;
#(
    parameter int NUM_LINES   = 2,
    parameter int ADDR_W      = 8,
    parameter int BASE_ADDR   = 'h40,
    parameter int ADDR_STRIDE = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [RATE_W-1:0]          bus_wdata,
    input  logic                       bus_rd,
    output logic [RATE_W-1:0]          bus_rdata,
    input  logic [NUM_LINES-1:0]       pwrup_req,
    output logic [NUM_LINES*IDX_W-1:0] rate_idx,
    output logic [NUM_LINES-1:0]       pll_en,
    output logic [NUM_LINES-1:0]       sleep_ok,
    output logic [NUM_LINES-1:0]       seq_err
);
    logic [NUM_LINES-1:0] sel;
    logic [RATE_W-1:0]    rate_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam logic [ADDR_W-1:0] LINE_ADDR = ADDR_W'(BASE_ADDR + ADDR_STRIDE*g);
        assign sel[g] = (bus_addr == LINE_ADDR);

        srate_chan chan_i (
            .clk       (clk),
            .rst       (rst),
            .wr_hit    (bus_wr && sel[g]),
            .wdata     (bus_wdata),
            .pwrup_req (pwrup_req[g]),
            .rate_q    (rate_q[g]),
            .idx_q     (rate_idx[g*IDX_W +: IDX_W]),
            .pll_en    (pll_en[g]),
            .sleep_ok  (sleep_ok[g]),
            .seq_err   (seq_err[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_LINES; i++)
            if (bus_rd && sel[i]) bus_rdata = bus_rdata | rate_q[i];
    end
endmodule

// File: rtl/srate_regs_chk.sv
module srate_regs_chk
    import srate_pkg::*;
#(
    parameter int NUM_LINES   = 2,
    parameter int ADDR_W      = 8,
    parameter int BASE_ADDR   = 'h40,
    parameter int ADDR_STRIDE = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic                       bus_wr,
    input logic [RATE_W-1:0]          bus_wdata,
    input logic                       bus_rd,
    input logic [RATE_W-1:0]          bus_rdata,
    input logic [NUM_LINES-1:0]       pwrup_req,
    input logic [NUM_LINES*IDX_W-1:0] rate_idx,
    input logic [NUM_LINES-1:0]       pll_en,
    input logic [NUM_LINES-1:0]       sleep_ok,
    input logic [NUM_LINES-1:0]       seq_err
);
    logic mapped;
    always_comb begin
        mapped = 1'b0;
        for (int i = 0; i < NUM_LINES; i++)
            if (bus_addr == ADDR_W'(BASE_ADDR + ADDR_STRIDE*i)) mapped = 1'b1;
    end

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd || !mapped) |-> bus_rdata == '0);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
        localparam logic [ADDR_W-1:0] A = ADDR_W'(BASE_ADDR + ADDR_STRIDE*g);

        a_r7_sleep_pll: assert property (@(posedge clk) disable iff (rst)
            sleep_ok[g] |-> pll_en[g]);
        a_r6_idx_off: assert property (@(posedge clk) disable iff (rst)
            pll_en[g] == (rate_idx[g*IDX_W +: IDX_W] != IDX_OFF));
        a_r6_zero_write: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == A && bus_wdata == '0) |=> !pll_en[g]);
        a_r6_read_pll: assert property (@(posedge clk) disable iff (rst)
            (bus_rd && bus_addr == A) |-> pll_en[g] == (bus_rdata != '0));
        a_r5_clamp: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == A && bus_wdata > CLAMP_LIMIT)
            |=> rate_idx[g*IDX_W +: IDX_W] == IDX_W'(NUM_RATES-1));
        a_r3_supported: assert property (@(posedge clk) disable iff (rst)
            (bus_rd && bus_addr == A && bus_rdata != '0) |-> is_supported(bus_rdata));
        a_r8_set: assert property (@(posedge clk) disable iff (rst)
            (pwrup_req[g] && !pll_en[g]) |=> seq_err[g]);
        a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
            seq_err[g] |=> seq_err[g]);
    end
endmodule

bind srate_regs srate_regs_chk #(
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR), .ADDR_STRIDE(ADDR_STRIDE)
) chk_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pwrup_req(pwrup_req), .rate_idx(rate_idx), .pll_en(pll_en),
    .sleep_ok(sleep_ok), .seq_err(seq_err)
);

// File: tb/srate_regs_tb.sv
`timescale 1ns/1ps
module srate_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic [1:0]  pwrup_req = '0;
    logic [7:0]  rate_idx;
    logic [1:0]  pll_en, sleep_ok, seq_err;

    int n_total = 0;
    int n_pass  = 0;
    bit done    = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    srate_regs dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pwrup_req(pwrup_req), .rate_idx(rate_idx), .pll_en(pll_en),
        .sleep_ok(sleep_ok), .seq_err(seq_err)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_total++;
        if (act === exp) n_pass++;
        else $display("FAIL %s: actual %h expected %h", tag, act, exp);
    endtask

    // monitor: pops one expected item per read cycle
    initial forever begin
        @(negedge clk);
        if (bus_rd) begin
            if (exp_q.size() == 0) begin
                n_total++;
                $display("FAIL R9: unexpected read, actual %h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic snap_case(input logic [7:0] a, input logic [15:0] d,
                             input logic [15:0] exp, input logic [3:0] eidx, input string tag);
        int ln;
        ln = (a == 8'h42) ? 1 : 0;
        wr(a, d);
        rd(a, exp, tag);
        @(negedge clk);
        check(tag, 16'(rate_idx[ln*4 +: 4]), 16'(eidx));
    endtask

    task automatic pwrup(input int ln);
        @(posedge clk); #1;
        pwrup_req[ln] = 1'b1;
        @(posedge clk); #1;
        pwrup_req = '0;
    endtask

    initial begin
        logic [15:0] codes [9];
        codes = '{16'h1C20, 16'h1F40, 16'h2024, 16'h20D0, 16'h2328,
                  16'h2580, 16'h282D, 16'h2EE0, 16'h3592};
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 idx", 16'(rate_idx), 16'hFF);
        check("R1 pll", 16'(pll_en), 16'h0);
        check("R1 err", 16'(seq_err), 16'h0);
        check("R7 sleep reset", 16'(sleep_ok), 16'h0);
        rd(8'h40, 16'h0000, "R1 line0");
        rd(8'h42, 16'h0000, "R1 line1");

        pwrup(1);
        @(negedge clk);
        check("R8 err on unprogrammed", 16'(seq_err), 16'h2);

        for (int i = 0; i < 9; i++)
            snap_case(8'h40, codes[i], codes[i], 4'(i), "R2 exact");

        snap_case(8'h40, 16'd100,   16'h1C20, 4'd0, "R3 below min");
        snap_case(8'h40, 16'd8300,  16'h2024, 4'd2, "R3 near lower");
        snap_case(8'h40, 16'd9500,  16'h2580, 4'd5, "R3 near upper");
        snap_case(8'h40, 16'd11500, 16'h2EE0, 4'd7, "R3 near 12000");
        snap_case(8'h40, 16'd7600,  16'h1C20, 4'd0, "R4 mid 7600");
        snap_case(8'h40, 16'd8114,  16'h1F40, 4'd1, "R4 mid 8114");
        snap_case(8'h40, 16'd9942,  16'h2580, 4'd5, "R4 mid 9942");
        snap_case(8'h40, 16'd9943,  16'h282D, 4'd6, "R4 above mid");
        snap_case(8'h40, 16'd12001, 16'h3592, 4'd8, "R5 just above");
        snap_case(8'h42, 16'hFFFF,  16'h3592, 4'd8, "R5 max line1");
        rd(8'h40, 16'h3592, "R10 line0 untouched");

        @(negedge clk);
        check("R7 sleep on", 16'(sleep_ok), 16'h3);
        snap_case(8'h40, 16'h0000, 16'h0000, 4'hF, "R6 zero");
        @(negedge clk);
        check("R6 pll off", 16'(pll_en), 16'h2);
        check("R7 sleep off", 16'(sleep_ok), 16'h2);

        snap_case(8'h40, 16'd9000, 16'h2328, 4'd4, "R8 program");
        pwrup(0);
        @(negedge clk);
        check("R8 no err when set", 16'(seq_err), 16'h2);
        snap_case(8'h40, 16'h0000, 16'h0000, 4'hF, "R8 clear rate");
        pwrup(0);
        @(negedge clk);
        check("R8 err set", 16'(seq_err), 16'h3);
        snap_case(8'h40, 16'd8000, 16'h1F40, 4'd1, "R8 reprogram");
        @(negedge clk);
        check("R8 sticky", 16'(seq_err), 16'h3);

        wr(8'h44, 16'h1C20);
        wr(8'h41, 16'h0000);
        rd(8'h44, 16'h0000, "R9 unmapped read");
        rd(8'h40, 16'h1F40, "R9 line0 unchanged");
        rd(8'h42, 16'h3592, "R9 line1 unchanged");
        @(negedge clk);
        bus_addr = 8'h40;
        #0.5;
        check("R9 rd low", bus_rdata, 16'h0000);

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_total++;
            $display("FAIL R10: %0d reads left, actual pending expected 0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_total++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end
endmodule